// File: doc/BRIEF.md
# Tick-Driven Match Timer

This block is a free-running timer peripheral for an operating-system tick. A 32-bit counter advances by one on every pulse of a tick enable that is synchronous to the bus clock. Four independent 32-bit compare channels watch the counter. When a tick moves the counter onto a channel's compare value, that channel raises a sticky event flag. Each channel then drives its own level-sensitive interrupt line for as long as its flag and its enable bit are both set.

Software works with the block through a simple word-wide register port. The port has an address, write data, a write strobe, a read strobe and registered read data. Software can load the counter at any time. It arms a channel by writing a compare value ahead of the count, and it acknowledges an event by writing a one to the flag bit. A compare value placed only a few ticks ahead of the count can be overtaken before the write lands, so software keeps a lead of more than 16 ticks. Any lead from 17 ticks up to 0x7FFFFFFF ticks fires, measured along the wrapping count.

Top module: `tick_match_timer`

## Requirements
- R1: On each cycle with `tick` high and no counter write, the counter advances by exactly one and wraps from 0xFFFFFFFF to 0. Without a tick or a write it holds its value.
- R2: A write to offset 0x10 loads the counter with the write data. A tick in the same cycle is overridden, and the next tick continues from the loaded value plus one.
- R3: Compare registers 0 to 3 sit at offsets 0x00, 0x04, 0x08 and 0x0C. Each stores all 32 bits and reads back what was written.
- R4: Flag bit n (offset 0x14, bit n) is set on the tick that moves the counter to a value equal to compare register n. An equality produced by writing the counter or the compare register does not set it.
- R5: Flags are sticky. Writing 1 to bit n of offset 0x14 clears flag n, and writing 0 leaves it unchanged. A set event in the same cycle as a clear leaves the flag set.
- R6: The enable register at offset 0x1C holds bit n for channel n. Bits above bit 3 are not stored and read as 0.
- R7: `irq[n]` is high exactly while flag n and enable bit n are both 1.
- R8: A compare value programmed D ticks ahead of the count, with 17 <= D <= 0x7FFFFFFF, sets its flag on exactly the D-th tick and not before. This includes cases where the count wraps through zero.
- R9: After reset the counter, the flags and the enable register read 0 and every `irq` line is low.
- R10: `bus_rdata` presents the addressed register in the cycle after a read strobe and is 0 in every other cycle. Offset 0x18 reads 0, and accesses with a nonzero address bit 1 or 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count enable |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit count and four channels. Because the counter is loadable, wrap-around through zero and a full 0x7FFFFFFF-tick lead are reached in a few dozen cycles. The bench places the counter just short of the compare value, so these cases need no long count. Random rounds draw a channel, a base count, a lead from 17 upward and an enable pattern. Each round checks that the flag stays clear one tick early and sets on the exact tick, and that the interrupt follows the enable. Directed cases cover write-made equalities, a clear colliding with a set, and a tick colliding with a counter load.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  // Word index (byte address bits [4:2]) of the fixed registers.
  localparam int unsigned WIX_CNT = 4;
  localparam int unsigned WIX_STS = 5;
  localparam int unsigned WIX_GAP = 6;
  localparam int unsigned WIX_EN  = 7;
endpackage

// File: rtl/tmt_counter.sv
module tmt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc
);
  assign step    = tick && !load;
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_inc;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q)); // R1
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val)); // R2
endmodule

// File: rtl/tmt_channel.sv
module tmt_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic             mwr,
  input  logic [CNT_W-1:0] mwdata,
  input  logic             sclr,
  output logic [CNT_W-1:0] match_q,
  output logic             sts_q
);
  logic hit;

  // Compare against the value the counter is about to take, so only a
  // tick can produce a hit; writes never do.
  assign hit = step && (cnt_inc == match_q);

  // No reset on the compare value: plain storage, cheap in fabric.
  always_ff @(posedge clk) begin
    if (mwr) match_q <= mwdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       sts_q <= 1'b0;
    else if (hit)  sts_q <= 1'b1;
    else if (sclr) sts_q <= 1'b0;
  end

  AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
    hit |=> sts_q); // R4
  AST_STS_ONLY_TICK: assert property (@(posedge clk) disable iff (rst)
    !step |=> !$rose(sts_q)); // R4
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !sclr) |=> sts_q); // R5
  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sclr && !hit) |=> !sts_q); // R5
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  import tmt_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              wr_ok;
  logic              rd_ok;
  logic              cnt_load;
  logic              step;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  match_q [NUM_CH];
  logic [NUM_CH-1:0] sts_q;
  logic [NUM_CH-1:0] en_q;
  logic [CNT_W-1:0]  rd_mux;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && aligned;
  assign rd_ok   = bus_rd && aligned;

  assign cnt_load = wr_ok && (idx == IDX_W'(WIX_CNT));

  tmt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (bus_wdata),
    .step     (step),
    .cnt_q    (cnt_q),
    .cnt_inc  (cnt_inc)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic mwr;
    logic sclr;
    assign mwr  = wr_ok && (idx == IDX_W'(g));
    assign sclr = wr_ok && (idx == IDX_W'(WIX_STS)) && bus_wdata[g];

    tmt_channel #(.CNT_W(CNT_W)) u_channel (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .cnt_inc (cnt_inc),
      .mwr     (mwr),
      .mwdata  (bus_wdata),
      .sclr    (sclr),
      .match_q (match_q[g]),
      .sts_q   (sts_q[g])
    );

    assign irq[g] = sts_q[g] && en_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)                                   en_q <= '0;
    else if (wr_ok && idx == IDX_W'(WIX_EN))   en_q <= bus_wdata[NUM_CH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx == IDX_W'(i)) rd_mux = match_q[i];
    end
    if (idx == IDX_W'(WIX_CNT)) rd_mux = cnt_q;
    if (idx == IDX_W'(WIX_STS)) rd_mux = {{(CNT_W-NUM_CH){1'b0}}, sts_q};
    if (idx == IDX_W'(WIX_EN))  rd_mux = {{(CNT_W-NUM_CH){1'b0}}, en_q};
    if (idx == IDX_W'(WIX_GAP)) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0); // R10
  AST_IRQ_FALLS_ON_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && idx == IDX_W'(WIX_EN) && bus_wdata[NUM_CH-1:0] == '0) |=> irq == '0); // R7
  AST_EN_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && aligned && idx == IDX_W'(WIX_EN)) |=> bus_rdata[CNT_W-1:NUM_CH] == '0); // R6
endmodule

// File: tb/tick_match_timer_bench.sv
module tick_match_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  tick_match_timer u_tick_match_timer (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [4:0] A_CNT = 5'h10, A_STS = 5'h14, A_GAP = 5'h18, A_EN = 5'h1C;

  function automatic logic [4:0] match_addr(int ch);
    return 5'(ch * 4);
  endfunction

  function automatic logic [31:0] lead_target(logic [31:0] base, logic [31:0] d);
    return base + d;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == A_CNT) exp_cnt = d;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      exp_cnt = exp_cnt + 32'd1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    rd(A_CNT, v); check("R9 counter", v, 0);
    rd(A_STS, v); check("R9 status", v, 0);
    rd(A_EN, v);  check("R9 enable", v, 0);
    check("R9 irq", 32'(irq), 0);

    // R3 compare registers hold full words
    for (int c = 0; c < 4; c++) wr(match_addr(c), 32'hA5000000 + 32'(c * 32'h01010101) + 32'h80000000);
    for (int c = 0; c < 4; c++) begin
      rd(match_addr(c), v);
      check("R3 match readback", v, 32'hA5000000 + 32'(c * 32'h01010101) + 32'h80000000);
    end
    wr(A_STS, 32'hF);

    // R10 gap offset and rdata idle; misaligned write ignored
    rd(A_GAP, v); check("R10 gap reads zero", v, 0);
    check("R10 rdata idle", bus_rdata, 0);
    @(negedge clk); bus_addr = 5'h11; bus_wdata = 32'h1234; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_CNT, v); check("R10 misaligned write ignored", v, exp_cnt);

    // R1 increment and hold; wrap
    ticks(5);
    rd(A_CNT, v); check("R1 count after 5 ticks", v, exp_cnt);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); check("R1 hold without tick", v, exp_cnt);
    wr(A_CNT, 32'hFFFFFFFE);
    ticks(3);
    rd(A_CNT, v); check("R1 wrap", v, 32'h00000001);

    // R6 enable width
    wr(A_EN, 32'hFFFFFFFF);
    rd(A_EN, v); check("R6 enable upper bits", v, 32'hF);
    wr(A_EN, 32'h0);

    // R4 write-made equality does not set
    wr(match_addr(0), 32'h100);
    wr(A_CNT, 32'h100);
    wr(A_STS, 32'hF);
    ticks(1);
    rd(A_STS, v); check("R4 counter-write equality", v & 32'h1, 0);
    wr(match_addr(0), exp_cnt);
    rd(A_STS, v); check("R4 match-write equality", v & 32'h1, 0);

    // R8 wrap-through-zero hit
    wr(match_addr(2), 32'h00000001);
    wr(A_CNT, 32'hFFFFFFF0);
    wr(A_STS, 32'hF);
    ticks(16);
    rd(A_STS, v); check("R8 wrap early", v & 32'h4, 0);
    ticks(1);
    rd(A_STS, v); check("R8 wrap exact", v & 32'h4, 32'h4);

    // R8 maximal lead
    wr(A_CNT, 32'h10);
    wr(match_addr(3), lead_target(32'h10, 32'h7FFFFFFF));
    wr(A_STS, 32'hF);
    ticks(5);
    rd(A_STS, v); check("R8 far lead idle", v & 32'h8, 0);
    wr(A_CNT, 32'h8000000F - 32'd17);
    ticks(16);
    rd(A_STS, v); check("R8 far lead early", v & 32'h8, 0);
    ticks(1);
    rd(A_STS, v); check("R8 far lead exact", v & 32'h8, 32'h8);

    // R5 sticky, write-zero, write-one clear
    ticks(3);
    wr(A_STS, 32'h0);
    rd(A_STS, v); check("R5 sticky after zero write", v & 32'h8, 32'h8);
    wr(A_STS, 32'h8);
    rd(A_STS, v); check("R5 clear by one", v & 32'h8, 0);

    // R5 set beats simultaneous clear
    wr(A_CNT, 32'h2000);
    wr(match_addr(1), 32'h2001);
    wr(A_STS, 32'hF);
    @(negedge clk);
    tick = 1'b1; bus_addr = A_STS; bus_wdata = 32'h2; bus_wr = 1'b1;
    exp_cnt = exp_cnt + 32'd1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(A_STS, v); check("R5 set wins over clear", v & 32'h2, 32'h2);

    // R2 load overrides tick
    @(negedge clk);
    tick = 1'b1; bus_addr = A_CNT; bus_wdata = 32'h500; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0; exp_cnt = 32'h500;
    rd(A_CNT, v); check("R2 load beats tick", v, 32'h500);
    ticks(1);
    rd(A_CNT, v); check("R2 continue after load", v, 32'h501);

    // R7 irq gating
    wr(A_EN, 32'h2);
    check("R7 irq enabled", 32'(irq), 32'h2);
    wr(A_EN, 32'h0);
    check("R7 irq masked", 32'(irq), 32'h0);
    wr(A_EN, 32'h2);
    wr(A_STS, 32'h2);
    check("R7 irq after clear", 32'(irq), 32'h0);

    // R8/R7 constrained random leads
    void'($urandom(32'd1234));
    for (int it = 0; it < 30; it++) begin
      int ch;
      logic [31:0] base, d, en;
      ch   = int'($urandom % 4);
      base = $urandom;
      d    = 32'd17 + ($urandom % 300);
      en   = $urandom % 16;
      wr(A_EN, en);
      wr(A_CNT, base);
      wr(match_addr(ch), lead_target(base, d));
      wr(A_STS, 32'hF);
      ticks(int'(d) - 1);
      rd(A_STS, v); check("R8 random early", (v >> ch) & 32'h1, 0);
      ticks(1);
      rd(A_STS, v); check("R8 random exact", (v >> ch) & 32'h1, 1);
      check("R7 random irq", 32'(irq[ch]), (en >> ch) & 32'h1);
      rd(A_CNT, v); check("R1 random count", v, exp_cnt);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule